// File: doc/BRIEF.md
# ISDN Terminal Layer-1 Activation Controller

This block is the activation and deactivation controller for the terminal end of an ISDN basic-rate S/T line. Once per 125 us frame, marked by a one-cycle `frame_stb`, it looks at two inputs: the line-signal indications from the receiver (INFO 0, INFO 2 or INFO 4 recognised) and a 4-bit command code from the command/indicate channel. It then moves between the deactivated, power-up, pending, unsynchronised, synchronised and activated states. It also has three override states for reset, test and loop.

For each state the block sends two fixed values: a 2-bit request that tells the line transmitter which signal to send, and a 4-bit indication code that goes back on the command/indicate channel. A command takes effect only after it has been seen at two consecutive frame strobes. The reset, test and loop commands win over every other condition in any state. The filter depth is a parameter.

Top module: `term_act_fsm`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the reset state, which reports indication 4'h0 with transmit request 2'd0 (silence). The command history is also cleared, so a command present before reset needs two strobes after reset before it acts.
- R2: `ind_code` and `tx_info` change only at a clock edge where `frame_stb` is high. At all other edges they hold their values.
- R3: A command acts only when its code is the same at this strobe and at the previous strobe. A code seen at one strobe only has no effect.
- R4: A stable reset command (4'h1), test command (4'h2) or loop command (4'hA) moves the block from any state to the reset state (4'h0, 2'd0), the test state (4'h2, 2'd2) or the loop state (4'hA, 2'd3). This takes precedence over every line indication and every other command.
- R5: The reset, test and loop states are left only by a stable deactivate command (4'hF), which leads to the deactivated state. Activation requests and line indications are ignored in these states.
- R6: The deactivated state reports 4'hF and 2'd0. From it, a recognised INFO 4 leads to the activated state (4'hC, 2'd3). Otherwise INFO 2 leads to the synchronised state (4'h8, 2'd3). Otherwise a stable activation request (4'h8 or 4'h9) leads to pending activation (4'h4, 2'd1). Otherwise a stable timing command (4'h0) leads to power-up (4'h7, 2'd0).
- R7: Power-up follows the same priority for INFO 4, INFO 2 and activation requests. A stable deactivate command returns it to the deactivated state.
- R8: Pending activation goes to the activated state on INFO 4, or to the synchronised state on INFO 2. A stable deactivate command returns it to the deactivated state. Otherwise it stays.
- R9: In the synchronised and activated states, the priority order is INFO 4 (to activated), then INFO 2 (to synchronised), then INFO 0 (to pending deactivation, 4'h6, 2'd0). With no recognised signal, the block goes to the unsynchronised state (4'h5, 2'd0).
- R10: Unsynchronised and pending deactivation go to the activated state on INFO 4, or to the synchronised state on INFO 2. Otherwise a stable deactivate command leads to the deactivated state. Otherwise they stay.
- R11: A command code that a state does not use, including the idle code 4'hE, leaves that state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe per 125 us frame |
| cmd_code | input | 4 | Command code from the command/indicate channel |
| rx_info0 | input | 1 | Receiver recognises INFO 0 |
| rx_info2 | input | 1 | Receiver recognises INFO 2 |
| rx_info4 | input | 1 | Receiver recognises INFO 4 |
| ind_code | output | 4 | Indication code for the current state |
| tx_info | output | 2 | Transmit request: 0 silence, 1 INFO 1, 2 test signal, 3 INFO 3 |

## Verification
Each state has its own indication code, so a wrong state shows up as a wrong `ind_code` at the edge where `frame_stb` is high, one cycle after the strobe input is driven. The bench walks a frame-by-frame table and compares the indication and transmit request after every strobe. A faulty command filter appears as a transition one frame too early or a missed one. A faulty priority appears as the wrong successor state when a command and a line indication arrive together.

// File: rtl/tafsm_pkg.sv
package tafsm_pkg;

   localparam int CODE_W = 4;
   localparam int TXR_W  = 2;

   typedef logic [CODE_W-1:0] code_t;
   typedef logic [TXR_W-1:0]  txreq_t;

   typedef enum logic [3:0] {
      ST_RESET, ST_TEST, ST_LOOP,
      ST_F3_DEACT, ST_F3_PWRUP, ST_F3_PEND,
      ST_F4_PEND, ST_F5_UNSYNC, ST_F6_SYNC, ST_F7_ACT
   } state_t;

   typedef struct packed {
      logic sig0;
      logic sig2;
      logic sig4;
   } line_t;

   typedef struct packed {
      code_t  ind;
      txreq_t tx;
   } out_t;

   // command codes
   localparam code_t CMD_TIMING = 4'h0;
   localparam code_t CMD_RESET  = 4'h1;
   localparam code_t CMD_TEST   = 4'h2;
   localparam code_t CMD_ACT_A  = 4'h8;
   localparam code_t CMD_ACT_B  = 4'h9;
   localparam code_t CMD_LOOP   = 4'hA;
   localparam code_t CMD_IDLE   = 4'hE;
   localparam code_t CMD_DEACT  = 4'hF;

   // indication codes
   localparam code_t IND_RESET  = 4'h0;
   localparam code_t IND_TEST   = 4'h2;
   localparam code_t IND_F4     = 4'h4;
   localparam code_t IND_F5     = 4'h5;
   localparam code_t IND_F3PEND = 4'h6;
   localparam code_t IND_F3PWR  = 4'h7;
   localparam code_t IND_F6     = 4'h8;
   localparam code_t IND_LOOP   = 4'hA;
   localparam code_t IND_F7     = 4'hC;
   localparam code_t IND_F3D    = 4'hF;

   // transmit requests
   localparam txreq_t TX_SILENT = 2'd0;
   localparam txreq_t TX_INFO1  = 2'd1;
   localparam txreq_t TX_TSIG   = 2'd2;
   localparam txreq_t TX_INFO3  = 2'd3;

   function automatic out_t decode_state(input state_t s);
      out_t o;
      case (s)
         ST_RESET:     o = '{ind: IND_RESET,  tx: TX_SILENT};
         ST_TEST:      o = '{ind: IND_TEST,   tx: TX_TSIG};
         ST_LOOP:      o = '{ind: IND_LOOP,   tx: TX_INFO3};
         ST_F3_DEACT:  o = '{ind: IND_F3D,    tx: TX_SILENT};
         ST_F3_PWRUP:  o = '{ind: IND_F3PWR,  tx: TX_SILENT};
         ST_F3_PEND:   o = '{ind: IND_F3PEND, tx: TX_SILENT};
         ST_F4_PEND:   o = '{ind: IND_F4,     tx: TX_INFO1};
         ST_F5_UNSYNC: o = '{ind: IND_F5,     tx: TX_SILENT};
         ST_F6_SYNC:   o = '{ind: IND_F6,     tx: TX_INFO3};
         ST_F7_ACT:    o = '{ind: IND_F7,     tx: TX_INFO3};
         default:      o = '{ind: IND_RESET,  tx: TX_SILENT};
      endcase
      return o;
   endfunction

endpackage

// File: rtl/tafsm_cmd_filter.sv
module tafsm_cmd_filter
   import tafsm_pkg::*;
#(
   parameter int STABLE_FRAMES = 2
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  frame_stb,
   input  code_t cmd_in,
   output logic  cmd_ok
);

   if (STABLE_FRAMES < 1) begin : g_bad_depth
      $error("tafsm_cmd_filter: STABLE_FRAMES must be at least 1");
   end

   if (STABLE_FRAMES == 1) begin : g_direct
      assign cmd_ok = 1'b1;
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst, frame_stb, cmd_in};
   end else begin : g_history
      localparam int HIST_N = STABLE_FRAMES - 1;
      code_t hist_q [HIST_N];

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < HIST_N; i++) hist_q[i] <= CMD_IDLE;
         end else if (frame_stb) begin
            hist_q[0] <= cmd_in;
            for (int i = 1; i < HIST_N; i++) hist_q[i] <= hist_q[i-1];
         end
      end

      always_comb begin
         cmd_ok = 1'b1;
         for (int i = 0; i < HIST_N; i++) begin
            if (hist_q[i] != cmd_in) cmd_ok = 1'b0;
         end
      end
   end

endmodule

// File: rtl/tafsm_next_state.sv
module tafsm_next_state
   import tafsm_pkg::*;
(
   input  state_t cur,
   input  code_t  cmd,
   input  logic   cmd_ok,
   input  line_t  line,
   output state_t nxt
);

   logic want_act, want_deact, want_timing;

   always_comb begin
      want_act    = cmd_ok && (cmd == CMD_ACT_A || cmd == CMD_ACT_B);
      want_deact  = cmd_ok && (cmd == CMD_DEACT);
      want_timing = cmd_ok && (cmd == CMD_TIMING);
   end

   always_comb begin
      nxt = cur;
      if (cmd_ok && cmd == CMD_RESET)      nxt = ST_RESET;
      else if (cmd_ok && cmd == CMD_TEST)  nxt = ST_TEST;
      else if (cmd_ok && cmd == CMD_LOOP)  nxt = ST_LOOP;
      else begin
         case (cur)
            ST_RESET, ST_TEST, ST_LOOP: begin
               if (want_deact) nxt = ST_F3_DEACT;
            end
            ST_F3_DEACT: begin
               if (line.sig4)        nxt = ST_F7_ACT;
               else if (line.sig2)   nxt = ST_F6_SYNC;
               else if (want_act)    nxt = ST_F4_PEND;
               else if (want_timing) nxt = ST_F3_PWRUP;
            end
            ST_F3_PWRUP: begin
               if (line.sig4)        nxt = ST_F7_ACT;
               else if (line.sig2)   nxt = ST_F6_SYNC;
               else if (want_act)    nxt = ST_F4_PEND;
               else if (want_deact)  nxt = ST_F3_DEACT;
            end
            ST_F4_PEND, ST_F5_UNSYNC, ST_F3_PEND: begin
               if (line.sig4)        nxt = ST_F7_ACT;
               else if (line.sig2)   nxt = ST_F6_SYNC;
               else if (want_deact)  nxt = ST_F3_DEACT;
            end
            ST_F6_SYNC, ST_F7_ACT: begin
               if (line.sig4)        nxt = ST_F7_ACT;
               else if (line.sig2)   nxt = ST_F6_SYNC;
               else if (line.sig0)   nxt = ST_F3_PEND;
               else                  nxt = ST_F5_UNSYNC;
            end
            default: nxt = ST_RESET;
         endcase
      end
   end

endmodule

// File: rtl/tafsm_out_reg.sv
module tafsm_out_reg
   import tafsm_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   load,
   input  state_t nxt,
   output code_t  ind,
   output txreq_t tx
);

   out_t dec, out_q;

   always_comb dec = decode_state(nxt);

   always_ff @(posedge clk) begin
      if (rst)       out_q <= decode_state(ST_RESET);
      else if (load) out_q <= dec;
   end

   assign ind = out_q.ind;
   assign tx  = out_q.tx;

endmodule

// File: rtl/term_act_fsm.sv
module term_act_fsm
   import tafsm_pkg::*;
#(
   parameter int STABLE_FRAMES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       frame_stb,
   input  logic [3:0] cmd_code,
   input  logic       rx_info0,
   input  logic       rx_info2,
   input  logic       rx_info4,
   output logic [3:0] ind_code,
   output logic [1:0] tx_info
);

   if (CODE_W != 4) begin : g_bad_code_w
      $error("term_act_fsm: command codes must be 4 bits");
   end

   state_t state_q, state_d;
   logic   cmd_ok;
   line_t  line;

   assign line = '{sig0: rx_info0, sig2: rx_info2, sig4: rx_info4};

   tafsm_cmd_filter #(.STABLE_FRAMES(STABLE_FRAMES)) u_filter (
      .clk       (clk),
      .rst       (rst),
      .frame_stb (frame_stb),
      .cmd_in    (cmd_code),
      .cmd_ok    (cmd_ok)
   );

   tafsm_next_state u_next (
      .cur    (state_q),
      .cmd    (cmd_code),
      .cmd_ok (cmd_ok),
      .line   (line),
      .nxt    (state_d)
   );

   always_ff @(posedge clk) begin
      if (rst)            state_q <= ST_RESET;
      else if (frame_stb) state_q <= state_d;
   end

   tafsm_out_reg u_out (
      .clk  (clk),
      .rst  (rst),
      .load (frame_stb),
      .nxt  (state_d),
      .ind  (ind_code),
      .tx   (tx_info)
   );

endmodule

// File: rtl/tafsm_chk.sv
module tafsm_chk
   import tafsm_pkg::*;
#(
   parameter int STABLE_FRAMES = 2
) (
   input logic       clk,
   input logic       rst,
   input logic       frame_stb,
   input logic [3:0] cmd_code,
   input logic       rx_info2,
   input logic       rx_info4,
   input logic [3:0] ind_code,
   input logic [1:0] tx_info
);

   code_t prev_cmd;

   always_ff @(posedge clk) begin
      if (rst)            prev_cmd <= CMD_IDLE;
      else if (frame_stb) prev_cmd <= cmd_code;
   end

   AST_RESET_OUT: assert property (@(posedge clk)
      rst |=> (ind_code == IND_RESET && tx_info == TX_SILENT)); // R1

   AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (rst)
      !frame_stb |=> ($stable(ind_code) && $stable(tx_info))); // R2

   AST_DEACT_SILENT: assert property (@(posedge clk) disable iff (rst)
      (ind_code == IND_F3D) |-> (tx_info == TX_SILENT)); // R6

   AST_F7_ENTRY: assert property (@(posedge clk) disable iff (rst)
      (ind_code == IND_F7 && $past(ind_code) != IND_F7) |-> $past(rx_info4)); // R9

   if (STABLE_FRAMES == 2) begin : g_two_frame
      AST_ONE_FRAME_CMD: assert property (@(posedge clk) disable iff (rst)
         (frame_stb && cmd_code != prev_cmd && ind_code == IND_F3D
          && !rx_info2 && !rx_info4) |=> (ind_code == IND_F3D)); // R3

      AST_UNCOND_RESET: assert property (@(posedge clk) disable iff (rst)
         (frame_stb && cmd_code == CMD_RESET && prev_cmd == CMD_RESET)
         |=> (ind_code == IND_RESET)); // R4

      AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (rst)
         (frame_stb && ind_code == IND_LOOP && cmd_code != CMD_RESET
          && cmd_code != CMD_TEST && cmd_code != CMD_DEACT)
         |=> (ind_code == IND_LOOP)); // R5
   end

endmodule

bind term_act_fsm tafsm_chk #(.STABLE_FRAMES(STABLE_FRAMES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .frame_stb (frame_stb),
   .cmd_code  (cmd_code),
   .rx_info2  (rx_info2),
   .rx_info4  (rx_info4),
   .ind_code  (ind_code),
   .tx_info   (tx_info)
);

// File: tb/term_act_fsm_tb.sv
module term_act_fsm_tb;

   logic       clk = 1'b0;
   logic       rst;
   logic       frame_stb;
   logic [3:0] cmd_code;
   logic       rx_info0, rx_info2, rx_info4;
   logic [3:0] ind_code;
   logic [1:0] tx_info;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   term_act_fsm u_dut (
      .clk       (clk),
      .rst       (rst),
      .frame_stb (frame_stb),
      .cmd_code  (cmd_code),
      .rx_info0  (rx_info0),
      .rx_info2  (rx_info2),
      .rx_info4  (rx_info4),
      .ind_code  (ind_code),
      .tx_info   (tx_info)
   );

   // {req, cmd, info0, info2, info4, exp_ind, exp_tx}
   localparam int NV = 39;
   localparam logic [16:0] VEC [NV] = '{
      {4'd3,  4'hF, 3'b000, 4'h0, 2'd0},  // R3 deactivate first frame
      {4'd5,  4'hF, 3'b000, 4'hF, 2'd0},  // R5 leave reset state
      {4'd11, 4'hE, 3'b000, 4'hF, 2'd0},  // R11 idle code
      {4'd3,  4'h0, 3'b000, 4'hF, 2'd0},  // R3 timing first frame
      {4'd6,  4'h0, 3'b000, 4'h7, 2'd0},  // R6 to power-up
      {4'd3,  4'h8, 3'b000, 4'h7, 2'd0},  // R3
      {4'd7,  4'h8, 3'b000, 4'h4, 2'd1},  // R7 to pending activation
      {4'd8,  4'hE, 3'b010, 4'h8, 2'd3},  // R8 INFO 2
      {4'd9,  4'hE, 3'b001, 4'hC, 2'd3},  // R9 INFO 4
      {4'd9,  4'hE, 3'b000, 4'h5, 2'd0},  // R9 signal lost
      {4'd10, 4'hE, 3'b001, 4'hC, 2'd3},  // R10 INFO 4 from unsync
      {4'd9,  4'hE, 3'b100, 4'h6, 2'd0},  // R9 INFO 0
      {4'd3,  4'hF, 3'b100, 4'h6, 2'd0},  // R3
      {4'd10, 4'hF, 3'b100, 4'hF, 2'd0},  // R10 pending deact to deact
      {4'd11, 4'hE, 3'b000, 4'hF, 2'd0},  // R11
      {4'd3,  4'h9, 3'b000, 4'hF, 2'd0},  // R3
      {4'd6,  4'h9, 3'b000, 4'h4, 2'd1},  // R6 second activation code
      {4'd8,  4'hE, 3'b000, 4'h4, 2'd1},  // R8 stays
      {4'd3,  4'h2, 3'b000, 4'h4, 2'd1},  // R3
      {4'd4,  4'h2, 3'b001, 4'h2, 2'd2},  // R4 test beats INFO 4
      {4'd3,  4'hA, 3'b000, 4'h2, 2'd2},  // R3
      {4'd4,  4'hA, 3'b000, 4'hA, 2'd3},  // R4 loop
      {4'd5,  4'h8, 3'b000, 4'hA, 2'd3},  // R5
      {4'd5,  4'h8, 3'b011, 4'hA, 2'd3},  // R5 activation and line ignored
      {4'd3,  4'hF, 3'b000, 4'hA, 2'd3},  // R3
      {4'd5,  4'hF, 3'b000, 4'hF, 2'd0},  // R5 leave loop
      {4'd6,  4'hE, 3'b011, 4'hC, 2'd3},  // R6 INFO 4 beats INFO 2
      {4'd3,  4'h1, 3'b001, 4'hC, 2'd3},  // R3
      {4'd4,  4'h1, 3'b001, 4'h0, 2'd0},  // R4 reset beats INFO 4
      {4'd3,  4'hF, 3'b000, 4'h0, 2'd0},  // R3
      {4'd5,  4'hF, 3'b000, 4'hF, 2'd0},  // R5
      {4'd3,  4'h8, 3'b000, 4'hF, 2'd0},  // R3
      {4'd6,  4'h8, 3'b010, 4'h8, 2'd3},  // R6 INFO 2 beats activation
      {4'd9,  4'hE, 3'b000, 4'h5, 2'd0},  // R9 sync lost
      {4'd3,  4'hF, 3'b000, 4'h5, 2'd0},  // R3
      {4'd10, 4'hF, 3'b000, 4'hF, 2'd0},  // R10 unsync to deact
      {4'd3,  4'h0, 3'b000, 4'hF, 2'd0},  // R3 alternating codes
      {4'd3,  4'h8, 3'b000, 4'hF, 2'd0},  // R3
      {4'd3,  4'h0, 3'b000, 4'hF, 2'd0}   // R3
   };

   task automatic check(input int req, input logic [3:0] e_ind, input logic [1:0] e_tx);
      n_chk++;
      if (ind_code !== e_ind || tx_info !== e_tx) begin
         n_fail++;
         $display("FAIL R%0d: ind=%h tx=%0d expected ind=%h tx=%0d",
                  req, ind_code, tx_info, e_ind, e_tx);
      end
   endtask

   task automatic frame(input logic [3:0] c, input logic [2:0] sig);
      @(negedge clk);
      cmd_code  = c;
      {rx_info0, rx_info2, rx_info4} = sig;
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; frame_stb = 1'b0; cmd_code = 4'hE;
      rx_info0 = 1'b0; rx_info2 = 1'b0; rx_info4 = 1'b0;
      repeat (3) @(negedge clk);
      check(1, 4'h0, 2'd0);  // R1 reset state
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         frame(VEC[i][16:13] == 4'd0 ? 4'hE : VEC[i][12:9], VEC[i][8:6]);
         check(int'(VEC[i][16:13]), VEC[i][5:2], VEC[i][1:0]);
      end

      // R2: inputs move without a strobe, outputs hold (state is deactivated)
      @(negedge clk);
      cmd_code = 4'h1; rx_info4 = 1'b1;
      repeat (5) @(negedge clk);
      check(2, 4'hF, 2'd0);
      cmd_code = 4'hE; rx_info4 = 1'b0;

      // R1: reset from an active state clears state and command history
      frame(4'hE, 3'b001);
      check(6, 4'hC, 2'd3);    // R6 to activated
      @(negedge clk);
      cmd_code = 4'hF;
      frame_stb = 1'b1;
      @(negedge clk);          // DEACT seen once before reset
      frame_stb = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(1, 4'h0, 2'd0);    // R1
      frame(4'hF, 3'b000);
      check(1, 4'h0, 2'd0);    // R1 history cleared, first frame only
      frame(4'hF, 3'b000);
      check(5, 4'hF, 2'd0);    // R5

      // R7: power-up returns on deactivate
      frame(4'h0, 3'b000);
      frame(4'h0, 3'b000);
      check(7, 4'h7, 2'd0);
      frame(4'hF, 3'b000);
      frame(4'hF, 3'b000);
      check(7, 4'hF, 2'd0);

      // R11: unused code in synchronised state with INFO 2 present
      frame(4'hE, 3'b010);
      check(6, 4'h8, 2'd3);
      frame(4'h3, 3'b010);
      frame(4'h3, 3'b010);
      check(11, 4'h8, 2'd3);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule